// File: doc/BRIEF.md
# Operand and Address Size Prefix Decoder

This block sits at the front of an instruction decode path and consumes instruction bytes one at a time. Each byte arrives with `in_valid`. Bytes that are prefixes are absorbed. Two of them, the operand-size override (66H) and the address-size override (67H), are remembered until the instruction ends. The first byte that is not a prefix is taken as the opcode. In that same cycle the block pulses `done` and reports the effective operand and address sizes for that one instruction. The prefix state is then cleared.

The default size on both axes depends on two inputs. In protected mode it is 32 bits when the code-segment default-size flag is set and 16 bits when it is clear. In real-address, virtual-8086 and system-management mode it is always 16 bits. Each override prefix flips the default on its own axis. The block also compares a supplied effective offset with the 64 KiB real-mode limit and flags a fault. If an instruction carries too many prefix bytes, the block flags a length fault and drops that instruction.

Top module: `size_prefix_decoder`

## Requirements
- R1: An accepted byte of 66H or 67H is consumed as a prefix and gives no `done` pulse.
- R2: With `cpu_mode` = 2'b00 (protected), both defaults are 32-bit (`op_size32`/`addr_size32` = 1) when `d_flag` is 1 and 16-bit (0) when it is 0.
- R3: With `cpu_mode` = 2'b01 (real), 2'b10 (virtual-8086) or 2'b11 (SMM), both defaults are 16-bit whatever `d_flag` carries.
- R4: A 66H prefix inverts the operand size, and a 67H prefix inverts the address size. The two act independently, so all four combinations can be reached.
- R5: An override affects only the instruction it precedes. The next opcode reports the default sizes unless it has its own prefixes.
- R6: A prefix repeated within one instruction counts once and does not flip the size back.
- R7: Bytes F0H, F2H, F3H, 26H, 2EH, 36H, 3EH, 64H and 65H are consumed as prefixes and leave both sizes unchanged.
- R8: `done` and the size outputs appear in the same cycle that the opcode byte is accepted. `cpu_mode` and `d_flag` take effect as sampled in that cycle, not as they were when the prefixes arrived. Idle cycles between bytes do not matter.
- R9: `ofs_fault` pulses with `done` when `cpu_mode` is real and `eff_offset` is above FFFFH, even when 67H selected 32-bit addressing. It stays low in every other mode and for offsets up to FFFFH.
- R10: Up to 14 prefix bytes per instruction are accepted. The 15th consecutive prefix raises a one-cycle `len_fault` with no `done`, and it clears the prefix state and the count without counting itself.
- R11: Reset clears any pending prefixes and holds `done`, `len_fault` and `ofs_fault` low while no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Instruction byte |
| d_flag | input | 1 | Code-segment default-size flag |
| cpu_mode | input | 2 | 00 protected, 01 real, 10 virtual-8086, 11 SMM |
| eff_offset | input | 32 | Effective offset for the current instruction |
| done | output | 1 | Opcode byte accepted this cycle |
| op_size32 | output | 1 | Effective operand size is 32-bit (else 16-bit) |
| addr_size32 | output | 1 | Effective address size is 32-bit (else 16-bit) |
| ofs_fault | output | 1 | Real-mode offset above FFFFH on this opcode |
| len_fault | output | 1 | Prefix count limit exceeded |

## Verification
The opcode report and the real-mode offset fault can land in the same cycle. The bench provokes this with a real-mode instruction that carries 67H and an offset of 10000H. The scoreboard then expects `done`, `addr_size32` = 1 and `ofs_fault` = 1 all in that one sample. The length fault and a following opcode are also driven back to back. For that case the scoreboard expects the fault pulse, and one cycle later a report that counts only the prefixes that came after the fault.

// File: rtl/sizedec_pkg.sv
package sizedec_pkg;

    typedef enum logic [1:0] {
        MODE_PROT = 2'b00,
        MODE_REAL = 2'b01,
        MODE_V86  = 2'b10,
        MODE_SMM  = 2'b11
    } cpu_mode_e;

    localparam logic [7:0] BYTE_OPSZ = 8'h66;
    localparam logic [7:0] BYTE_ADSZ = 8'h67;

    typedef struct packed {
        logic is_pfx;
        logic is_op;
        logic is_ad;
    } byte_class_t;

    typedef struct packed {
        logic op32;
        logic ad32;
    } size_attr_t;

    function automatic byte_class_t classify(input logic [7:0] b);
        byte_class_t c;
        c.is_op  = (b == BYTE_OPSZ);
        c.is_ad  = (b == BYTE_ADSZ);
        case (b)
            8'hF0, 8'hF2, 8'hF3,
            8'h26, 8'h2E, 8'h36, 8'h3E,
            8'h64, 8'h65,
            BYTE_OPSZ, BYTE_ADSZ: c.is_pfx = 1'b1;
            default:              c.is_pfx = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic wide_default(input cpu_mode_e m, input logic d);
        return (m == MODE_PROT) && d;
    endfunction

endpackage

// File: rtl/sd_byte_class.sv
module sd_byte_class
    import sizedec_pkg::*;
(
    input  logic [7:0]  in_byte,
    output byte_class_t cls
);
    always_comb begin
        cls = classify(in_byte);
    end
endmodule

// File: rtl/sd_prefix_track.sv
module sd_prefix_track
    import sizedec_pkg::*;
#(
    parameter int MAX_PFX = 14,
    localparam int CNT_W  = $clog2(MAX_PFX + 1)
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  byte_class_t cls,
    output logic        seen_op,
    output logic        seen_ad,
    output logic        opcode_hit,
    output logic        len_fault
);
    logic [CNT_W-1:0] cnt;
    logic             take_pfx;

    always_comb begin
        take_pfx   = in_valid && cls.is_pfx;
        opcode_hit = in_valid && !cls.is_pfx;
        len_fault  = take_pfx && (cnt == CNT_W'(MAX_PFX));
    end

    always_ff @(posedge clk) begin
        if (rst || opcode_hit || len_fault) begin
            cnt     <= '0;
            seen_op <= 1'b0;
            seen_ad <= 1'b0;
        end else if (take_pfx) begin
            cnt     <= cnt + 1'b1;
            seen_op <= seen_op | cls.is_op;
            seen_ad <= seen_ad | cls.is_ad;
        end
    end

    AST_FRESH_AFTER_OPCODE: assert property (@(posedge clk) disable iff (rst)
        opcode_hit |=> (!seen_op && !seen_ad && cnt == '0)); // R5
    AST_OPSZ_STICKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls.is_op && !len_fault) |=> seen_op); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_PFX)); // R10
    AST_LEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        len_fault |=> (cnt == '0 && !seen_op && !seen_ad)); // R10
endmodule

// File: rtl/sd_size_resolve.sv
module sd_size_resolve
    import sizedec_pkg::*;
#(
    parameter int OFS_W   = 32,
    parameter int LIMIT_W = 16
)(
    input  cpu_mode_e        mode,
    input  logic             d_flag,
    input  logic             seen_op,
    input  logic             seen_ad,
    input  logic             opcode_hit,
    input  logic [OFS_W-1:0] offset,
    output size_attr_t       attr,
    output logic             ofs_fault
);
    logic def32;
    logic above_limit;

    always_comb begin
        def32       = wide_default(mode, d_flag);
        attr.op32   = def32 ^ seen_op;
        attr.ad32   = def32 ^ seen_ad;
        above_limit = |offset[OFS_W-1:LIMIT_W];
        ofs_fault   = opcode_hit && (mode == MODE_REAL) && above_limit;
    end
endmodule

// File: rtl/size_prefix_decoder.sv
module size_prefix_decoder
    import sizedec_pkg::*;
#(
    parameter int MAX_PFX = 14,
    parameter int OFS_W   = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             d_flag,
    input  logic [1:0]       cpu_mode,
    input  logic [OFS_W-1:0] eff_offset,
    output logic             done,
    output logic             op_size32,
    output logic             addr_size32,
    output logic             ofs_fault,
    output logic             len_fault
);
    byte_class_t cls;
    logic        seen_op, seen_ad, opcode_hit;
    size_attr_t  attr;
    cpu_mode_e   mode;

    always_comb mode = cpu_mode_e'(cpu_mode);

    sd_byte_class u_class (
        .in_byte (in_byte),
        .cls     (cls)
    );

    sd_prefix_track #(.MAX_PFX(MAX_PFX)) u_track (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cls        (cls),
        .seen_op    (seen_op),
        .seen_ad    (seen_ad),
        .opcode_hit (opcode_hit),
        .len_fault  (len_fault)
    );

    sd_size_resolve #(.OFS_W(OFS_W), .LIMIT_W(16)) u_resolve (
        .mode       (mode),
        .d_flag     (d_flag),
        .seen_op    (seen_op),
        .seen_ad    (seen_ad),
        .opcode_hit (opcode_hit),
        .offset     (eff_offset),
        .attr       (attr),
        .ofs_fault  (ofs_fault)
    );

    always_comb begin
        done        = opcode_hit;
        op_size32   = attr.op32;
        addr_size32 = attr.ad32;
    end

    AST_OFS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ofs_fault |-> done); // R9
    AST_DONE_LEN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && len_fault)); // R10
    AST_NARROW_MODES: assert property (@(posedge clk) disable iff (rst)
        (done && cpu_mode != 2'b00 && !seen_op) |-> !op_size32); // R3
    AST_PFX_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_byte == 8'h66 || in_byte == 8'h67)) |-> !done); // R1
endmodule

// File: tb/size_prefix_decoder_test.sv
module size_prefix_decoder_test;

    typedef struct {
        bit    lenf;
        bit    op32;
        bit    ad32;
        bit    ofs;
        string tag;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  pq[$];
    int          errors = 0;
    int          checks = 0;

    logic        clk = 0, rst = 1, in_valid = 0, d_flag = 0;
    logic [7:0]  in_byte = 0;
    logic [1:0]  cpu_mode = 0;
    logic [31:0] eff_offset = 0;
    logic        done, op_size32, addr_size32, ofs_fault, len_fault;

    size_prefix_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .d_flag(d_flag), .cpu_mode(cpu_mode), .eff_offset(eff_offset),
        .done(done), .op_size32(op_size32), .addr_size32(addr_size32),
        .ofs_fault(ofs_fault), .len_fault(len_fault)
    );

    always #2 clk = ~clk;

    task automatic step(input logic v, input logic [7:0] b, input logic [1:0] m,
                        input logic d, input logic [31:0] o);
        @(posedge clk); #1;
        in_valid = v; in_byte = b; cpu_mode = m; d_flag = d; eff_offset = o;
    endtask

    task automatic push(input bit lf, input bit o32, input bit a32, input bit of, input string tag);
        exp_t e;
        e.lenf = lf; e.op32 = o32; e.ad32 = a32; e.ofs = of; e.tag = tag;
        sb.push_back(e);
    endtask

    // Prefixes come from pq; the expected result is modelled from the requirements.
    task automatic instr(input string tag, input logic [1:0] m, input logic d, input logic [31:0] o);
        bit s66 = 0, s67 = 0, def;
        int n = 0;
        foreach (pq[i]) begin
            n++;
            if (n > 14) begin
                push(1, 0, 0, 0, {tag, " len"});
                s66 = 0; s67 = 0; n = 0;
            end else begin
                if (pq[i] == 8'h66) s66 = 1;
                if (pq[i] == 8'h67) s67 = 1;
            end
            step(1, pq[i], m, d, o);
        end
        def = (m == 2'b00) && d;
        push(0, def ^ s66, def ^ s67, (m == 2'b01) && (o > 32'hFFFF), tag);
        step(1, 8'h89, m, d, o);
        step(0, 8'h00, m, d, o);
        pq.delete();
    endtask

    task automatic direct(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Monitor: compares each result with the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && (done || len_fault)) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected output actual done=%0b len=%0b expected none",
                         done, len_fault);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.lenf != len_fault || e.lenf == done ||
                    (!e.lenf && (e.op32 != op_size32 || e.ad32 != addr_size32 || e.ofs != ofs_fault))) begin
                    errors++;
                    $display("FAIL %s actual len=%0b done=%0b op32=%0b ad32=%0b ofs=%0b expected len=%0b op32=%0b ad32=%0b ofs=%0b",
                             e.tag, len_fault, done, op_size32, addr_size32, ofs_fault,
                             e.lenf, e.op32, e.ad32, e.ofs);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        direct(done, 0, "R11 done after reset");
        direct(len_fault, 0, "R11 len_fault after reset");
        direct(ofs_fault, 0, "R11 ofs_fault after reset");

        instr("R2 prot d0 plain", 2'b00, 0, 0);
        instr("R2 prot d1 plain", 2'b00, 1, 0);
        pq = {8'h66};               instr("R4 R1 prot d1 op flip", 2'b00, 1, 0);
        pq = {8'h67};               instr("R4 prot d0 addr flip", 2'b00, 0, 0);
        pq = {8'h66, 8'h67};        instr("R4 prot d0 both", 2'b00, 0, 0);
        instr("R5 next instr default", 2'b00, 0, 0);
        instr("R3 real d1 plain", 2'b01, 1, 0);
        pq = {8'h66};               instr("R3 v86 d1 op", 2'b10, 1, 0);
        pq = {8'h67};               instr("R3 smm d1 addr", 2'b11, 1, 0);
        pq = {8'h66, 8'h66, 8'h67, 8'h67, 8'h67}; instr("R6 repeats", 2'b00, 0, 0);
        pq = {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E}; instr("R7 other prefixes a", 2'b00, 1, 0);
        pq = {8'h36, 8'h3E, 8'h64, 8'h65};        instr("R7 other prefixes b", 2'b00, 0, 0);
        pq = {8'h67};               instr("R9 real 67 above limit", 2'b01, 0, 32'h0001_0000);
        instr("R9 real at limit", 2'b01, 0, 32'h0000_FFFF);
        instr("R9 prot large offset", 2'b00, 1, 32'h1234_5678);
        instr("R9 v86 large offset", 2'b10, 0, 32'h0002_0000);

        for (int i = 0; i < 13; i++) pq.push_back(8'hF0);
        pq.push_back(8'h66);
        instr("R10 fourteen prefixes", 2'b00, 0, 0);
        pq.push_back(8'h66);
        for (int i = 0; i < 14; i++) pq.push_back(8'hF2);
        pq.push_back(8'h67);
        instr("R10 fifteen prefixes", 2'b00, 0, 0);

        // R8: prefix under one mode, opcode under another, with idle gaps
        push(0, 0, 1, 0, "R8 mode sampled at opcode");
        step(1, 8'h66, 2'b01, 0, 0);
        step(0, 8'h00, 2'b01, 0, 0);
        step(0, 8'h00, 2'b01, 0, 0);
        step(1, 8'h89, 2'b00, 1, 0);
        step(0, 8'h00, 2'b00, 1, 0);

        // R11: reset discards a pending prefix
        step(1, 8'h66, 2'b00, 1, 0);
        step(0, 8'h00, 2'b00, 1, 0);
        rst = 1;
        @(posedge clk); #1 rst = 0;
        instr("R11 reset clears prefix", 2'b00, 1, 0);

        repeat (4) @(posedge clk);
        #1;
        direct(sb.size() == 0, 1, "R8 all expected results seen");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule